// File: doc/BRIEF.md
# Flash Status Toggle Poller

This block runs on the host side of a byte-wide flash device. Software has already issued a program or erase command to the device. The block then waits for the device's embedded algorithm to finish. It reads a status byte at a target address again and again, through a simple read port: a request, an address, returned data and a valid flag. The device flips status bit 6 on every read while the operation runs, so the block compares that bit across consecutive reads. Status bit 5 flags an internal error. When bit 5 is seen, the toggle is checked once more before the block declares a failure, because the device may have completed just as the error bit rose.

The same sequence serves program and erase operations. After an erase, the caller may give any address inside the sector being erased. After a successful program, the caller can ask for one more read of the programmed location. The block compares that byte with the byte that was meant to be written and reports a mismatch as a failure. The result is given as a one-cycle `done` pulse, with `pass` or `fail` held afterwards.

Top module: `flash_toggle_poller`

## Requirements
- R1: A `start` pulse sampled while idle is accepted. In the next cycle `busy` and `rdReq` are high, and `pass` and `fail` are both low.
- R2: While busy, `rdReq` stays high, and each read completes in the cycle in which `rdValid` is high. `rdAddr` equals the address latched at start for every read of the operation.
- R3: If bit 6 (the toggle bit) has the same value in the first and second status reads, the operation passes after exactly two reads, when verify is off.
- R4: If bit 6 differs between the two reads and bit 5 (the error bit) of the second read is 0, the block starts a new pair of status reads. This repeats for as long as the toggle continues.
- R5: If bit 6 differs and bit 5 of the second read is 1, the block makes two more status reads. If bit 6 is equal across those two reads, the result is pass.
- R6: If bit 6 still differs across those two recheck reads, the result is fail, and no verify read is made.
- R7: With `verifyEn` high at start, a status pass is followed by one more read at the same address. The result is pass only if the full byte equals `expData`, and fail otherwise.
- R8: `done` is high for exactly one cycle, and that cycle is the first cycle in which `busy` is low. In it, exactly one of `pass` and `fail` is high. Both hold their values until the next accepted start.
- R9: A `start` pulse while busy is ignored. The address, the verify choice and the read count of the running operation do not change.
- R10: After reset, `busy`, `done`, `pass`, `fail` and `rdReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (single-cycle pulse) |
| tgtAddr | input | AW | Status/verify address, latched at start |
| verifyEn | input | 1 | Request a data verify read after a status pass |
| expData | input | DW | Intended byte for the verify read |
| rdReq | output | 1 | Read request to the flash |
| rdAddr | output | AW | Read address |
| rdData | input | DW | Read data from the flash |
| rdValid | input | 1 | Read data valid, one cycle per completed read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation succeeded |
| fail | output | 1 | Operation failed |

## Verification
Status streams are generated with a chosen number of toggling reads before bit 6 settles and a chosen read from which bit 5 stays high. Settling at once separates the two-read pass from looping. An odd or even settle point moves the settle inside or across a read pair. An error bit that appears just before settling separates the recheck pass from a recheck fail. An error with a toggle that never stops forces the fail path. Verify runs with matching and single-bit-corrupted bytes show that the full byte is compared and that no verify read follows a failure. The read-latency jitter and a mid-operation start with a different address and verify flag show that data is sampled only on the handshake and that the running operation keeps its parameters.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_STAT_A  = 3'd1,
    ST_STAT_B  = 3'd2,
    ST_RECHK_A = 3'd3,
    ST_RECHK_B = 3'd4,
    ST_VERIFY  = 3'd5
  } pollState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch operation parameters, clear results
    logic capTgl;   // capture toggle bit of current read
    logic setPass;  // finish with pass
    logic setFail;  // finish with fail
  } pollStrobe_t;

endpackage

// File: rtl/flash_poll_dp.sv
module flash_poll_dp
  import flash_poll_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int TGL_BIT = 6,
  parameter int ERR_BIT = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  pollStrobe_t   strobe,
  input  logic [AW-1:0] tgtAddr,
  input  logic [DW-1:0] expData,
  input  logic          verifyEn,
  input  logic [DW-1:0] rdData,
  output logic [AW-1:0] rdAddr,
  output logic          tglSame,
  output logic          errSet,
  output logic          dataMatch,
  output logic          verifyReq,
  output logic          pass,
  output logic          fail,
  output logic          done
);

  logic [AW-1:0] addrQ;
  logic [DW-1:0] expQ;
  logic          verifyQ;
  logic          prevTglQ;
  logic          passQ;
  logic          failQ;
  logic          doneQ;

  // operation parameters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      expQ    <= '0;
      verifyQ <= 1'b0;
    end else if (strobe.load) begin
      addrQ   <= tgtAddr;
      expQ    <= expData;
      verifyQ <= verifyEn;
    end
  end

  // held toggle bit of the previous status read
  always_ff @(posedge clk) begin
    if (!rstN)              prevTglQ <= 1'b0;
    else if (strobe.capTgl) prevTglQ <= rdData[TGL_BIT];
  end

  // result flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      passQ <= 1'b0;
      failQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= strobe.setPass | strobe.setFail;
      if (strobe.load) begin
        passQ <= 1'b0;
        failQ <= 1'b0;
      end else if (strobe.setPass) begin
        passQ <= 1'b1;
      end else if (strobe.setFail) begin
        failQ <= 1'b1;
      end
    end
  end

  assign tglSame   = (rdData[TGL_BIT] == prevTglQ);
  assign errSet    = rdData[ERR_BIT];
  assign dataMatch = (rdData == expQ);
  assign verifyReq = verifyQ;
  assign rdAddr    = addrQ;
  assign pass      = passQ;
  assign fail      = failQ;
  assign done      = doneQ;

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        rdValid,
  input  logic        tglSame,
  input  logic        errSet,
  input  logic        dataMatch,
  input  logic        verifyReq,
  output pollStrobe_t strobe,
  output logic        rdReq,
  output logic        busy
);

  pollState_e stateQ;
  pollState_e stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNxt;
  end

  always_comb begin
    stateNxt = stateQ;
    strobe   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNxt    = ST_STAT_A;
        end
      end
      ST_STAT_A: begin
        if (rdValid) begin
          strobe.capTgl = 1'b1;
          stateNxt      = ST_STAT_B;
        end
      end
      ST_STAT_B: begin
        if (rdValid) begin
          if (tglSame) begin
            if (verifyReq) begin
              stateNxt = ST_VERIFY;
            end else begin
              strobe.setPass = 1'b1;
              stateNxt       = ST_IDLE;
            end
          end else if (!errSet) begin
            stateNxt = ST_STAT_A;
          end else begin
            stateNxt = ST_RECHK_A;
          end
        end
      end
      ST_RECHK_A: begin
        if (rdValid) begin
          strobe.capTgl = 1'b1;
          stateNxt      = ST_RECHK_B;
        end
      end
      ST_RECHK_B: begin
        if (rdValid) begin
          if (!tglSame) begin
            strobe.setFail = 1'b1;
            stateNxt       = ST_IDLE;
          end else if (verifyReq) begin
            stateNxt = ST_VERIFY;
          end else begin
            strobe.setPass = 1'b1;
            stateNxt       = ST_IDLE;
          end
        end
      end
      ST_VERIFY: begin
        if (rdValid) begin
          strobe.setPass = dataMatch;
          strobe.setFail = !dataMatch;
          stateNxt       = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign rdReq = (stateQ != ST_IDLE);
  assign busy  = (stateQ != ST_IDLE);

endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
  import flash_poll_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int TGL_BIT = 6,
  parameter int ERR_BIT = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [AW-1:0] tgtAddr,
  input  logic          verifyEn,
  input  logic [DW-1:0] expData,
  output logic          rdReq,
  output logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] rdData,
  input  logic          rdValid,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail
);

  pollStrobe_t strobe;
  logic        tglSame;
  logic        errSet;
  logic        dataMatch;
  logic        verifyReq;

  flash_poll_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .rdValid   (rdValid),
    .tglSame   (tglSame),
    .errSet    (errSet),
    .dataMatch (dataMatch),
    .verifyReq (verifyReq),
    .strobe    (strobe),
    .rdReq     (rdReq),
    .busy      (busy)
  );

  flash_poll_dp #(
    .AW      (AW),
    .DW      (DW),
    .TGL_BIT (TGL_BIT),
    .ERR_BIT (ERR_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .tgtAddr   (tgtAddr),
    .expData   (expData),
    .verifyEn  (verifyEn),
    .rdData    (rdData),
    .rdAddr    (rdAddr),
    .tglSame   (tglSame),
    .errSet    (errSet),
    .dataMatch (dataMatch),
    .verifyReq (verifyReq),
    .pass      (pass),
    .fail      (fail),
    .done      (done)
  );

endmodule

// File: rtl/flash_poll_chk.sv
module flash_poll_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          rdValid,
  input logic [AW-1:0] rdAddr,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          fail
);

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && !pass && !fail)); // R1

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(rdAddr)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R8

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pass ^ fail)); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(pass) && $stable(fail))); // R8

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !rdValid) |=> busy); // R9

endmodule

bind flash_toggle_poller flash_poll_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .rdValid (rdValid),
  .rdAddr  (rdAddr),
  .busy    (busy),
  .done    (done),
  .pass    (pass),
  .fail    (fail)
);

// File: tb/flash_toggle_poller_tb.sv
`timescale 1ns/1ps
module flash_toggle_poller_tb;

  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] tgtAddr = '0;
  logic          verifyEn = 1'b0;
  logic [DW-1:0] expData = '0;
  logic          rdReq;
  logic [AW-1:0] rdAddr;
  logic [DW-1:0] rdData = '0;
  logic          rdValid = 1'b0;
  logic          busy, done, pass, fail;

  int nChecks = 0;
  int nFail = 0;

  logic [7:0]    script [0:63];
  int            rdIdx = 0;
  int            addrErr = 0;
  int            waitCnt = 0;
  logic [AW-1:0] curAddr = '0;

  always #2 clk = ~clk;

  flash_toggle_poller #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .tgtAddr(tgtAddr),
    .verifyEn(verifyEn), .expData(expData), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdData(rdData), .rdValid(rdValid), .busy(busy), .done(done),
    .pass(pass), .fail(fail)
  );

  // flash read model: random latency, one-cycle valid
  always @(negedge clk) begin
    if (!rstN) begin
      rdValid = 1'b0;
      waitCnt = 0;
    end else if (rdValid) begin
      rdValid = 1'b0;
    end else if (rdReq) begin
      if (waitCnt == 0) begin
        rdData  = script[rdIdx & 63];
        rdValid = 1'b1;
        if (rdAddr != curAddr) addrErr++;
        rdIdx++;
        waitCnt = int'($urandom % 3);
      end else begin
        waitCnt--;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // status stream: bit 6 toggles on reads below k, then settles; bit 5 high from read e on
  function automatic void genScript(input int k, input int e);
    for (int j = 0; j < 64; j++) begin
      logic [7:0] b;
      b = 8'($urandom);
      b[6] = (j < k) ? j[0] : k[0];
      b[5] = (j >= e);
      script[j] = b;
    end
  endfunction

  // expected status walk from the requirements
  function automatic void walk(output int nReads, output bit sPass,
                               output bit rechk, output bit looped);
    int i = 0;
    looped = 1'b0;
    rechk  = 1'b0;
    sPass  = 1'b0;
    while (1) begin
      bit a, b;
      a = script[i][6];
      b = script[i+1][6];
      i += 2;
      if (a == b) begin sPass = 1'b1; break; end
      if (!script[i-1][5]) begin looped = 1'b1; continue; end
      rechk = 1'b1;
      sPass = (script[i][6] == script[i+1][6]);
      i += 2;
      break;
    end
    nReads = i;
  endfunction

  task automatic runOp(input int k, input int e, input bit vfy,
                       input bit memOk, input bit midStart);
    int nStat, expReads, cnt;
    bit sPass, rechk, looped, expPass;
    string tag;
    logic [7:0] expB;
    logic [AW-1:0] addr;
    genScript(k, e);
    walk(nStat, sPass, rechk, looped);
    expB = 8'($urandom);
    expReads = nStat;
    expPass  = sPass;
    if (rechk)       tag = sPass ? "R5" : "R6";
    else if (looped) tag = "R4";
    else             tag = "R3";
    if (vfy && sPass) begin
      script[nStat] = memOk ? expB : (expB ^ (8'h01 << ($urandom % 8)));
      expReads = nStat + 1;
      expPass  = memOk;
      tag = "R7";
    end
    addr    = AW'($urandom);
    curAddr = addr;
    rdIdx   = 0;
    addrErr = 0;
    @(negedge clk);
    tgtAddr  = addr;
    verifyEn = vfy;
    expData  = expB;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && rdReq && !pass && !fail, "R1", "busy/rdReq after start",
        {busy, rdReq, pass, fail}, 4'b1100);
    if (midStart) begin
      @(negedge clk);
      if (busy) begin
        start    = 1'b1;
        tgtAddr  = ~addr;
        verifyEn = !vfy;
        expData  = ~expB;
        @(negedge clk);
        start = 1'b0;
      end
    end
    cnt = 0;
    while (!done && cnt < 3000) begin
      @(negedge clk);
      cnt++;
    end
    chk(done == 1'b1, tag, "done seen", done, 1);
    chk(!busy, "R8", "busy low with done", busy, 0);
    chk(pass == expPass && fail == !expPass, tag, "pass/fail",
        {pass, fail}, {expPass, !expPass});
    chk(rdIdx == expReads, midStart ? "R9" : tag, "read count", rdIdx, expReads);
    chk(addrErr == 0, midStart ? "R9" : "R2", "address errors", addrErr, 0);
    @(negedge clk);
    chk(!done, "R8", "done width", done, 0);
    repeat (3) @(negedge clk);
    chk(pass == expPass && fail == !expPass && !busy, "R8", "result held",
        {busy, pass, fail}, {1'b0, expPass, !expPass});
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4417));
    for (int j = 0; j < 64; j++) script[j] = 8'h00;
    repeat (4) @(negedge clk);
    chk({busy, done, pass, fail, rdReq} == 5'b0, "R10", "reset outputs",
        {busy, done, pass, fail, rdReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({busy, done, pass, fail, rdReq} == 5'b0, "R10", "idle after reset",
        {busy, done, pass, fail, rdReq}, 0);

    runOp(0, 99, 1'b0, 1'b1, 1'b0);   // R3 immediate settle
    runOp(6, 99, 1'b0, 1'b1, 1'b0);   // R4 even settle point
    runOp(7, 99, 1'b0, 1'b1, 1'b0);   // R4 odd settle point
    runOp(4, 3, 1'b0, 1'b1, 1'b0);    // R5 error then settle
    runOp(64, 2, 1'b0, 1'b1, 1'b0);   // R6 error with ongoing toggle
    runOp(64, 2, 1'b1, 1'b1, 1'b0);   // R6 no verify read after fail
    runOp(2, 99, 1'b1, 1'b1, 1'b0);   // R7 verify match
    runOp(2, 99, 1'b1, 1'b0, 1'b0);   // R7 verify mismatch
    runOp(20, 99, 1'b0, 1'b1, 1'b1);  // R9 start while busy
    runOp(20, 99, 1'b1, 1'b1, 1'b1);  // R9 start while busy, verify on

    for (int n = 0; n < 40; n++) begin
      int k, e;
      k = ($urandom % 5 == 0) ? 64 : int'($urandom % 20);
      e = ($urandom % 3 == 0) ? int'($urandom % 20) : 99;
      if (k == 64 && e == 99) e = int'($urandom % 20);
      runOp(k, e, 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0));
    end

    summary();
    $finish;
  end

endmodule